// File: doc/BRIEF.md
# Time-Window Pulse Event Counter

This block sits after a time-to-digital converter that has already decoded each detector pulse into three numbers: a fine start delay and a fine stop delay, both in picoseconds, and a coarse count of whole reference-clock periods. From these it rebuilds the pulse width. The width is the fine start plus the coarse span, less the fine stop. A pulse counts as an event only when its width falls inside a two-sided time window. Pulses that are too short are treated as noise, and pulses that are too long are treated as afterpulse pile-up or other disturbances.

Accepted events are counted over a programmable gate. A default gate lasts one second of reference clocks, so the output reads directly as counts per second. At the end of each gate the count is latched to the output with a one-cycle strobe, and counting starts again from zero. The window limits and the gate length are register inputs. They are sampled only at a gate boundary, so every gate is counted under one consistent setting.

Top module: `pw_window_counter`

## Requirements
- R1: While `rst_n` is low, `count_out` is 0 and `count_valid` is 0. The first gate after reset lasts `DEF_GATE` cycles and uses window limits of 2000 ps and 7000 ps.
- R2: The width of a pulse is `fine_start + coarse * 3750 - fine_stop`, in picoseconds. `coarse` is an unsigned count of 3750 ps reference periods.
- R3: The window test is inclusive, `lim_lo <= width <= lim_hi`. A width equal to either limit is accepted, and a width one picosecond outside either limit is rejected.
- R4: A pulse whose computed width is negative is rejected.
- R5: A cycle with `meas_valid` low does not change the count, whatever the values on the measurement inputs.
- R6: A gate of G cycles ends on its G-th clock edge. In the following cycle `count_valid` is high for one cycle and `count_out` holds the number of pulses accepted during that gate.
- R7: A pulse presented in the last cycle of a gate is counted in the next gate, not in the gate that is closing.
- R8: The running count saturates at all-ones (2^CNT_W − 1) and does not wrap.
- R9: Changes to `lim_lo`, `lim_hi` and `gate_len` take effect only from the gate that starts after the next boundary. A `gate_len` of 0 is treated as 1.
- R10: `count_out` holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| meas_valid | input | 1 | A decoded measurement is present this cycle |
| fine_start | input | FINE_W | Rising-edge fine delay, in ps |
| fine_stop | input | FINE_W | Falling-edge fine delay, in ps |
| coarse | input | CRS_W | Whole reference periods spanned by the pulse |
| lim_lo | input | TX_W-1 | Lower width limit, in ps |
| lim_hi | input | TX_W-1 | Upper width limit, in ps |
| gate_len | input | GATE_W | Gate length in clock cycles |
| count_out | output | CNT_W | Event count of the last finished gate |
| count_valid | output | 1 | One-cycle strobe: `count_out` has just been updated |

## Verification
The width and the window test have no register stage, so a measurement presented in a cycle reaches the running count at that cycle's clock edge. The strobe and the latched count appear just after the edge that closes the gate. The bench drives inputs on the falling edge and updates its requirement-level model at the rising edge. It then samples `count_valid` and `count_out` on the next falling edge, so every result is compared in the cycle it is due. Because the model tracks the gate position itself, it also knows the exact boundary cycle, which is where the R7 and R9 stimulus is placed.

// File: rtl/pw_pkg.sv
package pw_pkg;
    // Reference clock period in picoseconds
    localparam int unsigned REF_PERIOD_PS = 3750;
    // Default window limits in picoseconds
    localparam int unsigned DEF_LO_PS     = 2000;
    localparam int unsigned DEF_HI_PS     = 7000;
    // One second of reference cycles
    localparam int unsigned SECOND_CYCLES = 266_666_667;
endpackage

// File: rtl/pw_interval.sv
module pw_interval #(
    parameter int FINE_W    = 12,
    parameter int CRS_W     = 8,
    parameter int PERIOD_PS = 3750,
    localparam int TX_W     = CRS_W + FINE_W + 2
) (
    input  logic [FINE_W-1:0] fine_start,
    input  logic [FINE_W-1:0] fine_stop,
    input  logic [CRS_W-1:0]  coarse,
    output logic [TX_W-1:0]   width
);
    logic [TX_W-1:0] span;

    always_comb begin
        // Two's-complement arithmetic: a too-large stop yields a negative value
        span  = TX_W'(coarse) * TX_W'(PERIOD_PS);
        width = TX_W'(fine_start) + span - TX_W'(fine_stop);
    end
endmodule

// File: rtl/pw_window.sv
module pw_window #(
    parameter int TX_W  = 22,
    localparam int LIM_W = TX_W - 1
) (
    input  logic             meas_valid,
    input  logic [TX_W-1:0]  width,
    input  logic [LIM_W-1:0] lo,
    input  logic [LIM_W-1:0] hi,
    output logic             hit
);
    logic             neg;
    logic [LIM_W-1:0] mag;

    always_comb begin
        neg = width[TX_W-1];
        mag = width[LIM_W-1:0];
        hit = meas_valid && !neg && (mag >= lo) && (mag <= hi);
    end
endmodule

// File: rtl/pw_gate_ctr.sv
module pw_gate_ctr #(
    parameter int LIM_W    = 21,
    parameter int CNT_W    = 16,
    parameter int GATE_W   = 32,
    parameter int DEF_GATE = 266_666_667,
    parameter int DEF_LO   = 2000,
    parameter int DEF_HI   = 7000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [LIM_W-1:0]  lim_lo,
    input  logic [LIM_W-1:0]  lim_hi,
    input  logic [GATE_W-1:0] gate_len,
    output logic [LIM_W-1:0]  lo_q,
    output logic [LIM_W-1:0]  hi_q,
    output logic [CNT_W-1:0]  count_out,
    output logic              count_valid
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [GATE_W-1:0] tmr;
        logic [GATE_W-1:0] gate;
        logic [LIM_W-1:0]  lo;
        logic [LIM_W-1:0]  hi;
        logic [CNT_W-1:0]  run;
        logic [CNT_W-1:0]  out;
        logic              vld;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic     bound;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        bound    = (st_q.tmr >= st_q.gate - GATE_W'(1));
        if (bound) begin
            st_d.tmr  = '0;
            st_d.gate = (gate_len == '0) ? GATE_W'(1) : gate_len;
            st_d.lo   = lim_lo;
            st_d.hi   = lim_hi;
            st_d.out  = st_q.run;
            st_d.vld  = 1'b1;
            // a pulse in the closing cycle opens the new gate's count
            st_d.run  = hit ? CNT_W'(1) : '0;
        end else begin
            st_d.tmr = st_q.tmr + GATE_W'(1);
            if (hit && st_q.run != CNT_MAX)
                st_d.run = st_q.run + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.tmr  <= '0;
            st_q.gate <= GATE_W'(DEF_GATE);
            st_q.lo   <= LIM_W'(DEF_LO);
            st_q.hi   <= LIM_W'(DEF_HI);
            st_q.run  <= '0;
            st_q.out  <= '0;
            st_q.vld  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lo_q        = st_q.lo;
    assign hi_q        = st_q.hi;
    assign count_out   = st_q.out;
    assign count_valid = st_q.vld;
endmodule

// File: rtl/pw_window_counter.sv
module pw_window_counter #(
    parameter int FINE_W    = 12,
    parameter int CRS_W     = 8,
    parameter int CNT_W     = 16,
    parameter int GATE_W    = 32,
    parameter int DEF_GATE  = pw_pkg::SECOND_CYCLES,
    localparam int TX_W     = CRS_W + FINE_W + 2,
    localparam int LIM_W    = TX_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              meas_valid,
    input  logic [FINE_W-1:0] fine_start,
    input  logic [FINE_W-1:0] fine_stop,
    input  logic [CRS_W-1:0]  coarse,
    input  logic [LIM_W-1:0]  lim_lo,
    input  logic [LIM_W-1:0]  lim_hi,
    input  logic [GATE_W-1:0] gate_len,
    output logic [CNT_W-1:0]  count_out,
    output logic              count_valid
);
    logic [TX_W-1:0]  width_w;
    logic [LIM_W-1:0] lo_w;
    logic [LIM_W-1:0] hi_w;
    logic             hit_w;

    pw_interval #(
        .FINE_W    (FINE_W),
        .CRS_W     (CRS_W),
        .PERIOD_PS (pw_pkg::REF_PERIOD_PS)
    ) u_interval (
        .fine_start (fine_start),
        .fine_stop  (fine_stop),
        .coarse     (coarse),
        .width      (width_w)
    );

    pw_window #(
        .TX_W (TX_W)
    ) u_window (
        .meas_valid (meas_valid),
        .width      (width_w),
        .lo         (lo_w),
        .hi         (hi_w),
        .hit        (hit_w)
    );

    pw_gate_ctr #(
        .LIM_W    (LIM_W),
        .CNT_W    (CNT_W),
        .GATE_W   (GATE_W),
        .DEF_GATE (DEF_GATE),
        .DEF_LO   (pw_pkg::DEF_LO_PS),
        .DEF_HI   (pw_pkg::DEF_HI_PS)
    ) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit         (hit_w),
        .lim_lo      (lim_lo),
        .lim_hi      (lim_hi),
        .gate_len    (gate_len),
        .lo_q        (lo_w),
        .hi_q        (hi_w),
        .count_out   (count_out),
        .count_valid (count_valid)
    );
endmodule

// File: rtl/pw_window_counter_chk.sv
module pw_window_counter_chk #(
    parameter int TX_W  = 22,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             meas_valid,
    input logic [TX_W-1:0]  width_w,
    input logic             hit_w,
    input logic [CNT_W-1:0] count_out,
    input logic             count_valid
);
    // R5
    invalid_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_w |-> meas_valid);

    // R4
    negative_rejected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_w |-> !width_w[TX_W-1]);

    // R10
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !count_valid |-> $stable(count_out));

    // R7
    single_cycle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_valid && $past(count_valid)) |-> (count_out <= CNT_W'(1)));
endmodule

bind pw_window_counter pw_window_counter_chk #(
    .TX_W  (TX_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .meas_valid  (meas_valid),
    .width_w     (width_w),
    .hit_w       (hit_w),
    .count_out   (count_out),
    .count_valid (count_valid)
);

// File: tb/pw_window_counter_bench.sv
module pw_window_counter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int FINE_W     = 12;
    localparam int CRS_W      = 8;
    localparam int CNT_W      = 4;
    localparam int GATE_W     = 32;
    localparam int DEF_GATE   = 12;
    localparam int TX_W       = CRS_W + FINE_W + 2;
    localparam int LIM_W      = TX_W - 1;
    localparam int MAXC       = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              meas_valid = 1'b0;
    logic [FINE_W-1:0] fine_start = '0;
    logic [FINE_W-1:0] fine_stop = '0;
    logic [CRS_W-1:0]  coarse = '0;
    logic [LIM_W-1:0]  lim_lo = LIM_W'(2000);
    logic [LIM_W-1:0]  lim_hi = LIM_W'(7000);
    logic [GATE_W-1:0] gate_len = GATE_W'(16);
    logic [CNT_W-1:0]  count_out;
    logic              count_valid;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    string tag = "R1";

    // model state
    int m_tmr = 0;
    int m_gate = DEF_GATE;
    longint m_lo = 2000;
    longint m_hi = 7000;
    int m_run = 0;
    int m_out = 0;
    bit m_vld = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pw_window_counter #(
        .FINE_W   (FINE_W),
        .CRS_W    (CRS_W),
        .CNT_W    (CNT_W),
        .GATE_W   (GATE_W),
        .DEF_GATE (DEF_GATE)
    ) u_pw_window_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .meas_valid  (meas_valid),
        .fine_start  (fine_start),
        .fine_stop   (fine_stop),
        .coarse      (coarse),
        .lim_lo      (lim_lo),
        .lim_hi      (lim_hi),
        .gate_len    (gate_len),
        .count_out   (count_out),
        .count_valid (count_valid)
    );

    function automatic longint width_of(int fs, int fe, int co);
        return longint'(fs) + longint'(co) * 3750 - longint'(fe);
    endfunction

    function automatic bit accept(bit v, int fs, int fe, int co, longint lo, longint hi);
        longint w = width_of(fs, fe, co);
        return v && (w >= 0) && (w >= lo) && (w <= hi);
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // one cycle: drive at falling edge, model at rising edge, compare at next falling edge
    task automatic step(bit v, int fs, int fe, int co);
        bit h;
        meas_valid = v;
        fine_start = FINE_W'(fs);
        fine_stop  = FINE_W'(fe);
        coarse     = CRS_W'(co);
        @(posedge clk);
        h = accept(v, fs, fe, co, m_lo, m_hi);
        if (m_tmr >= m_gate - 1) begin
            m_out  = m_run;
            m_vld  = 1'b1;
            m_run  = h ? 1 : 0;
            m_tmr  = 0;
            m_gate = (gate_len == 0) ? 1 : int'(gate_len);
            m_lo   = longint'(lim_lo);
            m_hi   = longint'(lim_hi);
        end else begin
            m_vld = 1'b0;
            m_tmr++;
            if (h && m_run < MAXC) m_run++;
        end
        @(negedge clk);
        check(count_valid == m_vld, {tag, " strobe R6"}, count_valid, m_vld);
        if (m_vld)
            check(count_out == CNT_W'(m_out), {tag, " gate count R6"}, count_out, m_out);
        else
            check(count_out == CNT_W'(m_out), {tag, " hold R10"}, count_out, m_out);
    endtask

    task automatic idle_to_boundary();
        while (m_tmr != m_gate - 1) step(1'b0, 0, 0, 0);
    endtask

    initial begin
        repeat (CLK_PERIOD * 100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(count_out == '0, "R1 reset count", count_out, 0);
        check(count_valid == 1'b0, "R1 reset strobe", count_valid, 0);
        rst_n = 1'b1;

        // R3: inclusive bounds under default limits in the first gate
        tag = "R3";
        step(1'b1, 2000, 0, 0);       // exactly lower: accepted
        step(1'b1, 3250, 0, 1);       // 3250+3750 = 7000: accepted
        step(1'b1, 1999, 0, 0);       // one below: rejected
        step(1'b1, 3251, 0, 1);       // 7001: rejected
        tag = "R4";
        step(1'b1, 0, 100, 0);        // negative width
        step(1'b1, 10, 3000, 0);      // negative width
        tag = "R5";
        step(1'b0, 3000, 0, 0);       // in window but not valid
        step(1'b0, 100, 0, 1);
        tag = "R2";
        step(1'b1, 100, 1000, 1);     // 2850: accepted
        step(1'b1, 3700, 3700, 2);    // 7500: rejected
        idle_to_boundary();           // first gate ends: expected 3
        step(1'b0, 0, 0, 0);

        // R7: pulse on the closing cycle of a gate counts next
        tag = "R7";
        idle_to_boundary();
        step(1'b1, 3000, 0, 0);
        idle_to_boundary();
        step(1'b0, 0, 0, 0);

        // R9: limit change mid-gate takes effect only next gate
        tag = "R9";
        step(1'b1, 3000, 0, 0);
        lim_lo   = LIM_W'(5000);
        gate_len = GATE_W'(9);
        step(1'b1, 3000, 0, 0);
        step(1'b1, 3000, 0, 0);
        idle_to_boundary();
        step(1'b0, 0, 0, 0);
        step(1'b1, 3000, 0, 0);       // now rejected
        step(1'b1, 2000, 0, 1);       // 5750 accepted
        idle_to_boundary();
        step(1'b0, 0, 0, 0);
        lim_lo   = LIM_W'(2000);
        gate_len = GATE_W'(0);        // treated as one cycle
        idle_to_boundary();
        step(1'b1, 3000, 0, 0);
        step(1'b1, 3000, 0, 0);
        step(1'b0, 0, 0, 0);

        // R8: saturation over a long gate of hits
        tag = "R8";
        gate_len = GATE_W'(24);
        step(1'b0, 0, 0, 0);
        gate_len = GATE_W'(6);
        for (int i = 0; i < 24; i++) step(1'b1, 3000, 0, 0);
        idle_to_boundary();
        step(1'b0, 0, 0, 0);

        // R2: random measurements and settings
        tag = "R2";
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 40) == 0) begin
                gate_len = GATE_W'($urandom_range(1, 30));
                lim_lo   = LIM_W'($urandom_range(0, 6000));
                lim_hi   = LIM_W'($urandom_range(3000, 12000));
            end
            step(1'($urandom_range(0, 1)), int'($urandom_range(0, 3749)),
                 int'($urandom_range(0, 3749)), int'($urandom_range(0, 3)));
        end
        idle_to_boundary();
        step(1'b0, 0, 0, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule